// File: doc/BRIEF.md
# Posted-CAS Latency Scheduler

This block sits on the device side of a DDR2-style memory and turns the command stream into internal timing points. Mode-register load commands program the CAS latency (CL), the additive latency (AL) and a high-temperature self-refresh enable. The two bank-address bits of a load pick which register is written.

READ and WRITE commands may be accepted before the row-to-column delay has elapsed, as long as AL does not exceed that delay. Each accepted column command waits AL clocks, then produces an internal-issue strobe. A later strobe marks where read data must begin (read latency, AL+CL) or where write data is expected (write latency, one clock less). Every strobe carries the bank and column of its command.

The AL and CL in force when a command is accepted travel with that command. A later mode load does not move timing points that are already scheduled.

Top module: `posted_cas_sched`

## Requirements
- R1: After reset, curAl is 0, curCl is 3, htSelfRefresh is 0, modeError is 0, and issueValid, rdStart and wrStart are all 0.
- R2: A load (cmdKind 3) with cmdBank 00 writes CL from cmdAddr[6:4] when the value is 2 to 7. A value of 0 or 1 leaves CL unchanged and raises modeError.
- R3: A load with cmdBank 01 writes AL from cmdAddr[5:3] when the value is 0 to 4. A value of 5 to 7 is reserved: it leaves AL unchanged and raises modeError.
- R4: A load with cmdBank 10 copies cmdAddr[7] into htSelfRefresh when every other cmdAddr bit is 0. If any other bit is set, nothing changes and modeError is raised. A load with cmdBank 11 changes no register and raises no error.
- R5: modeError is high for exactly the one cycle after the edge that accepts a bad load.
- R6: Take the accepting edge as edge 0. For a READ (cmdKind 1) or WRITE (cmdKind 2), issueValid is high between edge AL and edge AL+1. issueWrite, issueBank and issueCol (cmdAddr[9:0]) show that command.
- R7: For a READ, rdStart is high between edge AL+CL and edge AL+CL+1, with rdBank and rdCol of that READ.
- R8: For a WRITE, wrStart is high between edge AL+CL-1 and edge AL+CL, with wrBank and wrCol of that WRITE.
- R9: A column command can be accepted on every clock. None is lost or merged, including a READ whose rdStart falls in the same cycle as the wrStart of a later WRITE.
- R10: Each command keeps the AL and CL in force when it was accepted. A mode load after acceptance does not shift its strobes.
- R11: cmdKind 0 (no operation) produces no strobe and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdKind | input | 2 | 0 none, 1 READ, 2 WRITE, 3 mode-register load |
| cmdBank | input | 2 | Bank of a column command; register select of a load |
| cmdAddr | input | 14 | Load value, or column in bits 9:0 |
| curAl | output | 3 | Additive latency in force |
| curCl | output | 3 | CAS latency in force |
| htSelfRefresh | output | 1 | High-temperature self-refresh enable |
| modeError | output | 1 | Pulse after a rejected load |
| issueValid | output | 1 | Internal issue of a column command |
| issueWrite | output | 1 | Issued command is a WRITE |
| issueBank | output | 2 | Bank of issued command |
| issueCol | output | 10 | Column of issued command |
| rdStart | output | 1 | Read data starts this cycle |
| rdBank | output | 2 | Bank of that READ |
| rdCol | output | 10 | Column of that READ |
| wrStart | output | 1 | Write data expected this cycle |
| wrBank | output | 2 | Bank of that WRITE |
| wrCol | output | 10 | Column of that WRITE |

## Verification
The read-data strobe of one command and the write-data strobe of another land in the same cycle when a WRITE follows a READ by one clock. They also coincide when commands arrive back to back under mixed latencies. Such pairs are forced directly, and they also arise often in random runs of dense commands.

The bench keeps a per-cycle calendar of expected strobes built from the AL and CL of each command. It compares both strobes and their tags in every cycle. A slot where one strobe is suppressed, or shows the other command's tag, counts as a failure.

// File: rtl/posted_cas_pkg.sv
package posted_cas_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_LOAD  = 2'd3
  } cmdKind_e;

  // Strobe bundle from control to the datapath: one push per accepted
  // column command, carrying the latencies it must keep.
  typedef struct packed {
    logic       push;
    logic       isWrite;
    logic [2:0] alTag;
    logic [2:0] clTag;
  } pushStrobe_t;

endpackage

// File: rtl/posted_cas_ctrl.sv
module posted_cas_ctrl
  import posted_cas_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int BANK_W   = 2,
  parameter int AL_MAX   = 4,
  parameter int CL_MIN   = 2,
  parameter int CL_MAX   = 7,
  parameter int CL_RESET = 3,
  parameter int HT_BIT   = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cmdKind,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic [2:0]        alOut,
  output logic [2:0]        clOut,
  output logic              htOut,
  output logic              errOut,
  output pushStrobe_t       strobe
);

  localparam logic [2:0] AL_MAX_F   = 3'(AL_MAX);
  localparam logic [2:0] CL_MIN_F   = 3'(CL_MIN);
  localparam logic [2:0] CL_MAX_F   = 3'(CL_MAX);
  localparam logic [2:0] CL_RESET_F = 3'(CL_RESET);

  cmdKind_e          kindE;
  logic [2:0]        alReg, alNext;
  logic [2:0]        clReg, clNext;
  logic              htReg, htNext;
  logic              errReg, errNext;
  logic [2:0]        clField, alField;
  logic [ADDR_W-1:0] restBits;

  assign kindE   = cmdKind_e'(cmdKind);
  assign clField = cmdAddr[6:4];
  assign alField = cmdAddr[5:3];

  always_comb begin
    restBits         = cmdAddr;
    restBits[HT_BIT] = 1'b0;
  end

  // Mode-register decode: the bank bits pick the target register.
  always_comb begin
    alNext  = alReg;
    clNext  = clReg;
    htNext  = htReg;
    errNext = 1'b0;
    if (kindE == CMD_LOAD) begin
      unique case (cmdBank[1:0])
        2'b00: begin
          if (clField >= CL_MIN_F && clField <= CL_MAX_F) clNext = clField;
          else errNext = 1'b1;
        end
        2'b01: begin
          if (alField <= AL_MAX_F) alNext = alField;
          else errNext = 1'b1;
        end
        2'b10: begin
          if (restBits == '0) htNext = cmdAddr[HT_BIT];
          else errNext = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alReg  <= '0;
      clReg  <= CL_RESET_F;
      htReg  <= 1'b0;
      errReg <= 1'b0;
    end else begin
      alReg  <= alNext;
      clReg  <= clNext;
      htReg  <= htNext;
      errReg <= errNext;
    end
  end

  always_comb begin
    strobe.push    = (kindE == CMD_READ) || (kindE == CMD_WRITE);
    strobe.isWrite = (kindE == CMD_WRITE);
    strobe.alTag   = alReg;
    strobe.clTag   = clReg;
  end

  assign alOut  = alReg;
  assign clOut  = clReg;
  assign htOut  = htReg;
  assign errOut = errReg;

endmodule

// File: rtl/posted_cas_datapath.sv
module posted_cas_datapath
  import posted_cas_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  parameter int AL_MAX = 4,
  parameter int CL_MAX = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  pushStrobe_t       strobe,
  input  logic [BANK_W-1:0] inBank,
  input  logic [COL_W-1:0]  inCol,
  output logic              issueValid,
  output logic              issueWrite,
  output logic [BANK_W-1:0] issueBank,
  output logic [COL_W-1:0]  issueCol,
  output logic              rdStart,
  output logic [BANK_W-1:0] rdBank,
  output logic [COL_W-1:0]  rdCol,
  output logic              wrStart,
  output logic [BANK_W-1:0] wrBank,
  output logic [COL_W-1:0]  wrCol
);

  localparam int DEPTH = AL_MAX + CL_MAX + 1;
  localparam int LAT_W = $clog2(DEPTH + 2);

  logic [DEPTH-1:0]  stValid, stWrite;
  logic [BANK_W-1:0] stBank [DEPTH];
  logic [COL_W-1:0]  stCol  [DEPTH];
  logic [2:0]        stAl   [DEPTH];
  logic [2:0]        stCl   [DEPTH];
  logic [DEPTH-1:0]  issHit, rdHit, wrHit;

  // Stage 0 takes the new command.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stValid[0] <= 1'b0;
      stWrite[0] <= 1'b0;
      stBank[0]  <= '0;
      stCol[0]   <= '0;
      stAl[0]    <= '0;
      stCl[0]    <= '0;
    end else begin
      stValid[0] <= strobe.push;
      stWrite[0] <= strobe.isWrite;
      stBank[0]  <= inBank;
      stCol[0]   <= inCol;
      stAl[0]    <= strobe.alTag;
      stCl[0]    <= strobe.clTag;
    end
  end

  // Each later stage ages its entry by one clock.
  for (genvar s = 1; s < DEPTH; s++) begin : g_shift
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stValid[s] <= 1'b0;
        stWrite[s] <= 1'b0;
        stBank[s]  <= '0;
        stCol[s]   <= '0;
        stAl[s]    <= '0;
        stCl[s]    <= '0;
      end else begin
        stValid[s] <= stValid[s-1];
        stWrite[s] <= stWrite[s-1];
        stBank[s]  <= stBank[s-1];
        stCol[s]   <= stCol[s-1];
        stAl[s]    <= stAl[s-1];
        stCl[s]    <= stCl[s-1];
      end
    end
  end

  // An entry at stage s is s clocks past its accepting edge.
  for (genvar s = 0; s < DEPTH; s++) begin : g_taps
    logic [LAT_W-1:0] rlSum;
    assign rlSum    = LAT_W'(stAl[s]) + LAT_W'(stCl[s]);
    assign issHit[s] = stValid[s] && (LAT_W'(stAl[s]) == LAT_W'(s));
    assign rdHit[s]  = stValid[s] && !stWrite[s] && (rlSum == LAT_W'(s));
    assign wrHit[s]  = stValid[s] && stWrite[s] && (rlSum == LAT_W'(s + 1));
  end

  // Tag select: the oldest hitting entry wins (later loop step overrides).
  always_comb begin
    issueWrite = 1'b0;
    issueBank  = '0;
    issueCol   = '0;
    rdBank     = '0;
    rdCol      = '0;
    wrBank     = '0;
    wrCol      = '0;
    for (int s = 0; s < DEPTH; s++) begin
      if (issHit[s]) begin
        issueWrite = stWrite[s];
        issueBank  = stBank[s];
        issueCol   = stCol[s];
      end
      if (rdHit[s]) begin
        rdBank = stBank[s];
        rdCol  = stCol[s];
      end
      if (wrHit[s]) begin
        wrBank = stBank[s];
        wrCol  = stCol[s];
      end
    end
  end

  assign issueValid = |issHit;
  assign rdStart    = |rdHit;
  assign wrStart    = |wrHit;

endmodule

// File: rtl/posted_cas_sched.sv
module posted_cas_sched
  import posted_cas_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int BANK_W   = 2,
  parameter int COL_W    = 10,
  parameter int AL_MAX   = 4,
  parameter int CL_MIN   = 2,
  parameter int CL_MAX   = 7,
  parameter int CL_RESET = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cmdKind,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic [2:0]        curAl,
  output logic [2:0]        curCl,
  output logic              htSelfRefresh,
  output logic              modeError,
  output logic              issueValid,
  output logic              issueWrite,
  output logic [BANK_W-1:0] issueBank,
  output logic [COL_W-1:0]  issueCol,
  output logic              rdStart,
  output logic [BANK_W-1:0] rdBank,
  output logic [COL_W-1:0]  rdCol,
  output logic              wrStart,
  output logic [BANK_W-1:0] wrBank,
  output logic [COL_W-1:0]  wrCol
);

  pushStrobe_t strobe;

  posted_cas_ctrl #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .AL_MAX(AL_MAX),
    .CL_MIN(CL_MIN), .CL_MAX(CL_MAX), .CL_RESET(CL_RESET), .HT_BIT(7)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cmdKind(cmdKind), .cmdBank(cmdBank), .cmdAddr(cmdAddr),
    .alOut(curAl), .clOut(curCl), .htOut(htSelfRefresh), .errOut(modeError),
    .strobe(strobe)
  );

  posted_cas_datapath #(
    .BANK_W(BANK_W), .COL_W(COL_W), .AL_MAX(AL_MAX), .CL_MAX(CL_MAX)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .inBank(cmdBank), .inCol(cmdAddr[COL_W-1:0]),
    .issueValid(issueValid), .issueWrite(issueWrite),
    .issueBank(issueBank), .issueCol(issueCol),
    .rdStart(rdStart), .rdBank(rdBank), .rdCol(rdCol),
    .wrStart(wrStart), .wrBank(wrBank), .wrCol(wrCol)
  );

endmodule

// File: rtl/posted_cas_checker.sv
module posted_cas_checker #(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 2,
  parameter int AL_MAX = 4,
  parameter int CL_MIN = 2,
  parameter int CL_MAX = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        cmdKind,
  input logic [BANK_W-1:0] cmdBank,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [2:0]        curAl,
  input logic [2:0]        curCl,
  input logic              htSelfRefresh,
  input logic              modeError,
  input logic              issueValid
);

  logic isLoad, isCol, emr2Clean;
  assign isLoad    = (cmdKind == 2'd3);
  assign isCol     = (cmdKind == 2'd1) || (cmdKind == 2'd2);
  assign emr2Clean = ((cmdAddr & ~(ADDR_W'(1) << 7)) == '0);

  // R3: AL never leaves its legal range
  p_al_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    32'(curAl) <= AL_MAX);

  // R2: CL never leaves its legal range
  p_cl_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    32'(curCl) >= CL_MIN && 32'(curCl) <= CL_MAX);

  // R3: a reserved AL load is rejected and flagged
  p_bad_al_keep_r3: assert property (@(posedge clk) disable iff (!rstN)
    (isLoad && cmdBank[1:0] == 2'b01 && 32'(cmdAddr[5:3]) > AL_MAX)
      |=> (modeError && curAl == $past(curAl)));

  // R5: an error pulse always follows a load
  p_err_src_r5: assert property (@(posedge clk) disable iff (!rstN)
    modeError |-> $past(isLoad));

  // R4: a clean EMR2 load sets the self-refresh enable
  p_ht_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (isLoad && cmdBank[1:0] == 2'b10 && emr2Clean)
      |=> (htSelfRefresh == $past(cmdAddr[7]) && !modeError));

  // R6: with AL zero the issue strobe follows the accepting edge at once
  p_issue_al0_r6: assert property (@(posedge clk) disable iff (!rstN)
    (isCol && curAl == 3'd0) |=> issueValid);

endmodule

bind posted_cas_sched posted_cas_checker #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .AL_MAX(AL_MAX),
  .CL_MIN(CL_MIN), .CL_MAX(CL_MAX)
) chk_i (
  .clk(clk), .rstN(rstN), .cmdKind(cmdKind), .cmdBank(cmdBank),
  .cmdAddr(cmdAddr), .curAl(curAl), .curCl(curCl),
  .htSelfRefresh(htSelfRefresh), .modeError(modeError),
  .issueValid(issueValid)
);

// File: tb/posted_cas_sched_tb_top.sv
module posted_cas_sched_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cmdKind = 2'd0;
  logic [1:0]  cmdBank = 2'd0;
  logic [13:0] cmdAddr = 14'd0;
  logic [2:0]  curAl, curCl;
  logic        htSelfRefresh, modeError;
  logic        issueValid, issueWrite, rdStart, wrStart;
  logic [1:0]  issueBank, rdBank, wrBank;
  logic [9:0]  issueCol, rdCol, wrCol;

  always #4 clk = ~clk;

  posted_cas_sched dut_i (
    .clk(clk), .rstN(rstN), .cmdKind(cmdKind), .cmdBank(cmdBank),
    .cmdAddr(cmdAddr), .curAl(curAl), .curCl(curCl),
    .htSelfRefresh(htSelfRefresh), .modeError(modeError),
    .issueValid(issueValid), .issueWrite(issueWrite),
    .issueBank(issueBank), .issueCol(issueCol),
    .rdStart(rdStart), .rdBank(rdBank), .rdCol(rdCol),
    .wrStart(wrStart), .wrBank(wrBank), .wrCol(wrCol)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  // Bench model of the mode registers
  int mAl = 0, mCl = 3, mHt = 0;

  // Calendar of expected strobes, indexed by edge number mod 64
  bit expIss [64];
  bit expIssW[64];
  int expIssB[64];
  int expIssC[64];
  bit expRd  [64];
  int expRdB [64];
  int expRdC [64];
  bit expWr  [64];
  int expWrB [64];
  int expWrC [64];
  bit expErr [64];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Compare every output against the calendar for the edge just passed.
  task automatic checkCycle();
    int i = cyc % 64;
    chk(issueValid == expIss[i], "R6 issueValid", int'(issueValid), int'(expIss[i]));
    if (expIss[i] && issueValid) begin
      chk(issueWrite == expIssW[i], "R6 issueWrite", int'(issueWrite), int'(expIssW[i]));
      chk(int'(issueBank) == expIssB[i], "R6 issueBank", int'(issueBank), expIssB[i]);
      chk(int'(issueCol) == expIssC[i], "R6 issueCol", int'(issueCol), expIssC[i]);
    end
    chk(rdStart == expRd[i], "R7 rdStart", int'(rdStart), int'(expRd[i]));
    if (expRd[i] && rdStart) begin
      chk(int'(rdBank) == expRdB[i], "R7 rdBank", int'(rdBank), expRdB[i]);
      chk(int'(rdCol) == expRdC[i], "R7 rdCol", int'(rdCol), expRdC[i]);
    end
    chk(wrStart == expWr[i], "R8 wrStart", int'(wrStart), int'(expWr[i]));
    if (expWr[i] && wrStart) begin
      chk(int'(wrBank) == expWrB[i], "R8 wrBank", int'(wrBank), expWrB[i]);
      chk(int'(wrCol) == expWrC[i], "R8 wrCol", int'(wrCol), expWrC[i]);
    end
    chk(modeError == expErr[i], "R5 modeError", int'(modeError), int'(expErr[i]));
    chk(int'(curAl) == mAl, "R3 curAl", int'(curAl), mAl);
    chk(int'(curCl) == mCl, "R2 curCl", int'(curCl), mCl);
    chk(int'(htSelfRefresh) == mHt, "R4 htSelfRefresh", int'(htSelfRefresh), mHt);
    expIss[i] = 0; expRd[i] = 0; expWr[i] = 0; expErr[i] = 0;
  endtask

  // Bench function: does a load with this select and value get rejected
  function automatic bit loadBad(input int sel, input int addr);
    case (sel)
      0: return (((addr >> 4) & 7) < 2);
      1: return (((addr >> 3) & 7) > 4);
      2: return ((addr & 14'h3F7F) != 0);
      default: return 0;
    endcase
  endfunction

  // One clock: check, then drive a command for the next edge and schedule it.
  task automatic tick(input int kind, input int bank, input int addr);
    int acc;
    @(negedge clk);
    checkCycle();
    cmdKind = 2'(kind);
    cmdBank = 2'(bank);
    cmdAddr = 14'(addr);
    acc = cyc + 1;
    if (kind == 1 || kind == 2) begin
      int ii = (acc + mAl) % 64;
      expIss[ii] = 1; expIssW[ii] = (kind == 2);
      expIssB[ii] = bank; expIssC[ii] = addr & 10'h3FF;
      if (kind == 1) begin
        int ri = (acc + mAl + mCl) % 64;
        expRd[ri] = 1; expRdB[ri] = bank; expRdC[ri] = addr & 10'h3FF;
      end else begin
        int wi = (acc + mAl + mCl - 1) % 64;
        expWr[wi] = 1; expWrB[wi] = bank; expWrC[wi] = addr & 10'h3FF;
      end
    end else if (kind == 3) begin
      if (loadBad(bank, addr)) expErr[acc % 64] = 1;
      else begin
        case (bank)
          0: mCl = (addr >> 4) & 7;
          1: mAl = (addr >> 3) & 7;
          2: mHt = (addr >> 7) & 1;
          default: ;
        endcase
      end
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick(0, 0, 0);
  endtask

  task automatic setLat(input int al, input int cl);
    tick(3, 1, al << 3);
    tick(3, 0, cl << 4);
    idle(14);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    summary();
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(curAl == 3'd0, "R1 curAl", int'(curAl), 0);
    chk(curCl == 3'd3, "R1 curCl", int'(curCl), 3);
    chk(htSelfRefresh == 1'b0, "R1 htSelfRefresh", int'(htSelfRefresh), 0);
    chk(modeError == 1'b0, "R1 modeError", int'(modeError), 0);
    chk(!issueValid && !rdStart && !wrStart, "R1 strobes", int'(issueValid | rdStart | wrStart), 0);
    rstN = 1'b1;
    idle(2);

    // R2: CL load, then reserved values
    tick(3, 0, 5 << 4);
    tick(3, 0, 1 << 4);
    tick(3, 0, 0);
    // R3: AL loads, legal and reserved
    tick(3, 1, 4 << 3);
    tick(3, 1, 5 << 3);
    tick(3, 1, 7 << 3);
    // R4: EMR2 enable, dirty write, EMR3 has no effect
    tick(3, 2, 1 << 7);
    tick(3, 2, (1 << 7) | (1 << 2));
    tick(3, 3, 14'h3FFF);
    tick(3, 2, 0);
    tick(3, 3, 1 << 7);
    idle(3);

    // R6 R7 R8: smallest latency pair
    setLat(0, 2);
    tick(1, 1, 10'h155);
    idle(4);
    tick(2, 2, 10'h2AA);
    idle(6);
    // R7 R8: read and write data strobes in the same cycle (R9)
    tick(1, 3, 10'h011);
    tick(2, 0, 10'h022);
    idle(8);
    // R6 R7 R8: largest latency
    setLat(4, 7);
    tick(1, 2, 10'h3FF);
    tick(2, 1, 10'h001);
    tick(1, 0, 10'h100);
    idle(14);
    // R10: latencies captured at acceptance, then changed
    setLat(4, 3);
    tick(1, 1, 10'h0F0);
    tick(3, 1, 0);
    tick(3, 0, 6 << 4);
    idle(14);
    // R11: no-op cycles with noisy fields change nothing
    for (int k = 0; k < 6; k++) tick(0, $urandom % 4, $urandom % 16384);
    idle(2);

    // R9: dense random phases, some reserved AL loads mixed in
    for (int ph = 0; ph < 12; ph++) begin
      setLat($urandom % 5, 2 + $urandom % 6);
      for (int k = 0; k < 60; k++) begin
        int r = $urandom % 16;
        if (r == 15) tick(3, 1, (5 + $urandom % 3) << 3);
        else if (r < 2) tick(0, $urandom % 4, $urandom % 16384);
        else tick(1 + (r % 2), $urandom % 4, $urandom % 1024);
      end
      idle(14);
    end

    summary();
  end

endmodule